// File: doc/BRIEF.md
# Flash Read Line Buffer

This block sits in front of a slow flash array on the read path of a single bus master. It keeps one page of the array (a group of `WORDS` consecutive data words) with a tag and a valid flag. It compares every accepted read address against that page. A read that hits is answered in the very next cycle, so its data phase has no wait states. A read that misses holds the master. The block first spends a fixed arbitration window and then issues one page request to the array. It waits for the page to return, captures the whole page into the buffer, and then ends the data phase with the requested word.

The master side is a pipelined request/ready handshake. A request is accepted on a clock edge where `m_req` and `m_ready` are both high. The data phase of that request runs from that edge until the first cycle in which `m_ready` is high again, and in that cycle `m_rdata` carries the word. A flush input drops the buffered page, so the next read fetches from the array again.

Top module: `flash_line_buffer`

## Requirements
- R1: After reset, `m_ready` is high and `arr_req` is low, and the buffer holds no valid page, so the first read is a miss.
- R2: A read whose word address falls in the buffered valid page has zero wait states: `m_ready` stays high in the cycle after acceptance, and `m_rdata` holds the word at that address.
- R3: On a miss, `m_ready` goes low in the cycle after acceptance. After `ARB_CYC` arbitration cycles, `arr_req` is high for exactly one cycle, with `arr_page` equal to the word address shifted right by log2(`WORDS`). With `ARB_CYC`=1 and an array that answers one cycle after the request cycle, the miss costs three wait states.
- R4: In the cycle after `arr_valid`, the requested word appears on `m_rdata` with `m_ready` high. Word k of `arr_line` occupies bits [k*DATA_W +: DATA_W]. The captured page makes the other words of that page hit afterwards.
- R5: A request presented while a miss is outstanding is not accepted while `m_ready` is low. It is accepted at the first edge where `m_ready` is high again, and it sees the freshly loaded page.
- R6: A flush pulse clears the valid flag, so the next read of the buffered page is a miss.
- R7: A flush that is high on the same edge as an acceptance forces that read to be treated as a miss.
- R8: A flush that is high during an outstanding fill still returns the fetched word, but it leaves the page invalid, so the next read of that page misses.
- R9: `m_rdata` does not change while `m_ready` is low.
- R10: A miss on a different page replaces the buffered page, and a later read of the old page misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master read request (address phase) |
| m_addr | input | ADDR_W | Master word address |
| m_ready | output | 1 | High when the data phase ends and a new request may be accepted |
| m_rdata | output | DATA_W | Read data, valid when `m_ready` is high after an acceptance |
| flush | input | 1 | Clears the buffered page's valid flag |
| arr_req | output | 1 | One-cycle page read request to the array |
| arr_page | output | ADDR_W-log2(WORDS) | Page address of the array request |
| arr_valid | input | 1 | Array page data valid |
| arr_line | input | DATA_W*WORDS | Page data from the array |

## Verification
A stale valid flag or a wrong tag shows up as a read that finishes with zero wait states but returns the wrong page's word. The scoreboard catches this at the end of that same data phase. If valid is stuck low, hits turn into misses: the wait-state count rises to three, and every one of them issues an array request, so the first re-read of a page exposes it. A bad fill-state sequence shows up as a wrong wait count, an extra or misplaced `arr_req`, or a data word that changes while `m_ready` is low. All of these are visible within the data phase of the read that is affected.

// File: rtl/flb_pkg.sv
package flb_pkg;
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ARB   = 2'd1,
    FS_FETCH = 2'd2
  } fill_state_t;
endpackage

// File: rtl/flb_word_sel.sv
module flb_word_sel #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int OFF_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int PAGE_W = DATA_W * WORDS
) (
  input  logic [PAGE_W-1:0] line,
  input  logic [OFF_W-1:0]  sel,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] slots [WORDS];

  for (genvar k = 0; k < WORDS; k++) begin : g_slot
    assign slots[k] = line[k*DATA_W +: DATA_W];
  end

  always_comb begin
    word = slots[0];
    for (int k = 1; k < WORDS; k++) begin
      if (sel == OFF_W'(k)) word = slots[k];
    end
  end
endmodule

// File: rtl/flb_line_store.sv
module flb_line_store #(
  parameter int TAG_W  = 14,
  parameter int PAGE_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [PAGE_W-1:0] fill_line,
  input  logic              fill_keep,
  input  logic              flush,
  output logic              hit,
  output logic              valid_o,
  output logic [PAGE_W-1:0] line_o
);
  logic              valid_q;
  logic [TAG_W-1:0]  tag_q;
  logic [PAGE_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst)          valid_q <= 1'b0;
    else if (fill_en) valid_q <= fill_keep;
    else if (flush)   valid_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q  <= fill_tag;
      line_q <= fill_line;
    end
  end

  assign hit     = valid_q && (tag_q == look_tag);
  assign valid_o = valid_q;
  assign line_o  = line_q;
endmodule

// File: rtl/flb_fill_ctrl.sv
module flb_fill_ctrl
  import flb_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  parameter int ARB_CYC = 1,
  localparam int OFF_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int CNT_W  = (ARB_CYC > 1) ? $clog2(ARB_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_req,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic              hit,
  input  logic              flush,
  input  logic [DATA_W-1:0] hit_word,
  input  logic [DATA_W-1:0] fill_word,
  input  logic              arr_valid,
  output logic              m_ready,
  output logic [DATA_W-1:0] m_rdata,
  output logic              arr_req,
  output logic [TAG_W-1:0]  arr_page,
  output logic              fill_en,
  output logic              fill_keep,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [OFF_W-1:0]  fill_off,
  output logic              fetching
);
  fill_state_t       state_q;
  logic              ready_q;
  logic [DATA_W-1:0] rdata_q;
  logic              areq_q;
  logic [TAG_W-1:0]  page_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              stale_q;
  logic              accept;
  logic              look_hit;

  assign accept   = m_req && ready_q && (state_q == FS_IDLE);
  assign look_hit = hit && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FS_IDLE;
      ready_q <= 1'b1;
      rdata_q <= '0;
      areq_q  <= 1'b0;
      page_q  <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      stale_q <= 1'b0;
    end else begin
      areq_q <= 1'b0;
      unique case (state_q)
        FS_IDLE: begin
          if (accept) begin
            if (look_hit) begin
              rdata_q <= hit_word;
            end else begin
              ready_q <= 1'b0;
              addr_q  <= m_addr;
              stale_q <= 1'b0;
              if (ARB_CYC == 0) begin
                state_q <= FS_FETCH;
                areq_q  <= 1'b1;
                page_q  <= m_addr[ADDR_W-1:OFF_W];
              end else begin
                state_q <= FS_ARB;
                cnt_q   <= CNT_W'(ARB_CYC - 1);
              end
            end
          end
        end
        FS_ARB: begin
          if (flush) stale_q <= 1'b1;
          if (cnt_q == '0) begin
            state_q <= FS_FETCH;
            areq_q  <= 1'b1;
            page_q  <= addr_q[ADDR_W-1:OFF_W];
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        FS_FETCH: begin
          if (arr_valid) begin
            rdata_q <= fill_word;
            ready_q <= 1'b1;
            stale_q <= 1'b0;
            state_q <= FS_IDLE;
          end else if (flush) begin
            stale_q <= 1'b1;
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign fill_en   = (state_q == FS_FETCH) && arr_valid;
  assign fill_keep = !stale_q && !flush;
  assign fill_tag  = addr_q[ADDR_W-1:OFF_W];
  assign fill_off  = addr_q[OFF_W-1:0];
  assign fetching  = (state_q != FS_IDLE);
  assign m_ready   = ready_q;
  assign m_rdata   = rdata_q;
  assign arr_req   = areq_q;
  assign arr_page  = page_q;
endmodule

// File: rtl/flash_line_buffer.sv
module flash_line_buffer #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  parameter int ARB_CYC = 1,
  localparam int OFF_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int PAGE_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_req,
  input  logic [ADDR_W-1:0] m_addr,
  output logic              m_ready,
  output logic [DATA_W-1:0] m_rdata,
  input  logic              flush,
  output logic              arr_req,
  output logic [TAG_W-1:0]  arr_page,
  input  logic              arr_valid,
  input  logic [PAGE_W-1:0] arr_line
);
  logic              hit;
  logic              buf_valid;
  logic [PAGE_W-1:0] buf_line;
  logic [DATA_W-1:0] hit_word;
  logic [DATA_W-1:0] fill_word;
  logic              fill_en;
  logic              fill_keep;
  logic [TAG_W-1:0]  fill_tag;
  logic [OFF_W-1:0]  fill_off;
  logic              fetching;

  flb_line_store #(.TAG_W(TAG_W), .PAGE_W(PAGE_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .look_tag  (m_addr[ADDR_W-1:OFF_W]),
    .fill_en   (fill_en),
    .fill_tag  (fill_tag),
    .fill_line (arr_line),
    .fill_keep (fill_keep),
    .flush     (flush),
    .hit       (hit),
    .valid_o   (buf_valid),
    .line_o    (buf_line)
  );

  flb_word_sel #(.DATA_W(DATA_W), .WORDS(WORDS)) u_hit_sel (
    .line (buf_line),
    .sel  (m_addr[OFF_W-1:0]),
    .word (hit_word)
  );

  flb_word_sel #(.DATA_W(DATA_W), .WORDS(WORDS)) u_fill_sel (
    .line (arr_line),
    .sel  (fill_off),
    .word (fill_word)
  );

  flb_fill_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .ARB_CYC(ARB_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .m_req     (m_req),
    .m_addr    (m_addr),
    .hit       (hit),
    .flush     (flush),
    .hit_word  (hit_word),
    .fill_word (fill_word),
    .arr_valid (arr_valid),
    .m_ready   (m_ready),
    .m_rdata   (m_rdata),
    .arr_req   (arr_req),
    .arr_page  (arr_page),
    .fill_en   (fill_en),
    .fill_keep (fill_keep),
    .fill_tag  (fill_tag),
    .fill_off  (fill_off),
    .fetching  (fetching)
  );
endmodule

// File: rtl/flb_checker.sv
module flb_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              m_req,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_rdata,
  input logic              flush,
  input logic              arr_req,
  input logic              hit,
  input logic              buf_valid,
  input logic              fill_en,
  input logic              fetching
);
  // R2: a hit at acceptance keeps the data phase at zero wait states
  a_r2_hit_no_wait: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_ready && hit && !flush) |=> m_ready);

  // R3 / R7: a miss (including one forced by flush) stalls the master
  a_r3_miss_stalls: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_ready && !(hit && !flush)) |=> !m_ready);

  // R3: array request is a single-cycle pulse
  a_r3_req_pulse: assert property (@(posedge clk) disable iff (rst)
    arr_req |=> !arr_req);

  // R5: while the array is being asked, the master is held off
  a_r5_hold_off: assert property (@(posedge clk) disable iff (rst)
    arr_req |-> (!m_ready && fetching));

  // R4: page capture ends the data phase in the next cycle
  a_r4_fill_done: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (m_ready && !fetching));

  // R6: flush outside a capture leaves the buffer invalid
  a_r6_flush_clears: assert property (@(posedge clk) disable iff (rst)
    (flush && !fill_en) |=> !buf_valid);

  // R8: a capture coinciding with flush leaves the page invalid
  a_r8_flush_on_fill: assert property (@(posedge clk) disable iff (rst)
    (fill_en && flush) |=> !buf_valid);

  // R9: read data holds while the master is stalled
  a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
    !m_ready |-> $stable(m_rdata));
endmodule

bind flash_line_buffer flb_checker #(.DATA_W(DATA_W)) u_flb_checker (
  .clk       (clk),
  .rst       (rst),
  .m_req     (m_req),
  .m_ready   (m_ready),
  .m_rdata   (m_rdata),
  .flush     (flush),
  .arr_req   (arr_req),
  .hit       (hit),
  .buf_valid (buf_valid),
  .fill_en   (fill_en),
  .fetching  (fetching)
);

// File: tb/flash_line_buffer_tb_top.sv
module flash_line_buffer_tb_top;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int WORDS   = 4;
  localparam int ARB_CYC = 1;
  localparam int OFF_W   = 2;
  localparam int TAG_W   = ADDR_W - OFF_W;
  localparam int PAGE_W  = DATA_W * WORDS;
  localparam int MISS_WS = 3;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    int                waits;
    string             req;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              m_req = 1'b0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic              m_ready;
  logic [DATA_W-1:0] m_rdata;
  logic              flush = 1'b0;
  logic              arr_req;
  logic [TAG_W-1:0]  arr_page;
  logic              arr_valid = 1'b0;
  logic [PAGE_W-1:0] arr_line = '0;

  int total = 0;
  int bad   = 0;
  item_t sb[$];

  always #2 clk = ~clk;

  flash_line_buffer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .ARB_CYC(ARB_CYC)
  ) dut_i (
    .clk(clk), .rst(rst), .m_req(m_req), .m_addr(m_addr),
    .m_ready(m_ready), .m_rdata(m_rdata), .flush(flush),
    .arr_req(arr_req), .arr_page(arr_page),
    .arr_valid(arr_valid), .arr_line(arr_line)
  );

  function automatic logic [DATA_W-1:0] fword(logic [ADDR_W-1:0] a);
    return {a, ~a} ^ 32'h3C3C_0000;
  endfunction

  function automatic logic [PAGE_W-1:0] fpage(logic [TAG_W-1:0] p);
    logic [PAGE_W-1:0] l;
    for (int k = 0; k < WORDS; k++) l[k*DATA_W +: DATA_W] = fword({p, OFF_W'(k)});
    return l;
  endfunction

  // flash model: answers one cycle after the request cycle
  always @(posedge clk) begin
    arr_valid <= arr_req;
    if (arr_req) arr_line <= fpage(arr_page);
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: one read, pushed to the scoreboard, with optional flush in the address phase
  task automatic rd(logic [ADDR_W-1:0] a, int ws, string req, bit fl = 1'b0);
    item_t it;
    it.addr = a; it.data = fword(a); it.waits = ws; it.req = req;
    sb.push_back(it);
    m_req = 1'b1; m_addr = a;
    if (fl) flush = 1'b1;
    forever begin
      @(negedge clk);
      if (m_ready) break;
    end
    @(posedge clk); #1;
    m_req = 1'b0;
    if (fl) flush = 1'b0;
  endtask

  task automatic pulse_flush();
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  // monitor
  bit                dp_act = 1'b0;
  int                wcnt   = 0;
  logic [DATA_W-1:0] prev_rdata = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (dp_act) begin
        if (m_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R2", "unexpected completion", 0, 1);
          end else begin
            item_t it;
            it = sb.pop_front();
            check(m_rdata == it.data, it.req, "rdata", m_rdata, it.data);
            check(wcnt == it.waits, it.req, "wait states", wcnt, it.waits);
          end
          dp_act = 1'b0;
        end else begin
          wcnt++;
          check(m_rdata == prev_rdata, "R9", "rdata moved while stalled", m_rdata, prev_rdata);
        end
      end
      if (arr_req) begin
        if (sb.size() != 0)
          check(arr_page == sb[0].addr[ADDR_W-1:OFF_W] && sb[0].waits != 0, "R3",
                "array page", arr_page, sb[0].addr[ADDR_W-1:OFF_W]);
        else
          check(1'b0, "R3", "array request with nothing pending", 1, 0);
      end
      if (m_req && m_ready) begin
        dp_act = 1'b1;
        wcnt   = 0;
      end
      prev_rdata = m_rdata;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(m_ready == 1'b1, "R1", "ready after reset", m_ready, 1);
    check(arr_req == 1'b0, "R1", "arr_req after reset", arr_req, 0);
    @(posedge clk); #1;

    rd(16'h0010, MISS_WS, "R1");          // first read misses
    rd(16'h0011, 0, "R2");
    rd(16'h0013, 0, "R4");
    rd(16'h0012, 0, "R2");
    rd(16'h0010, 0, "R4");

    rd(16'h0100, MISS_WS, "R10");         // new page replaces old
    rd(16'h0103, 0, "R10");
    rd(16'h0010, MISS_WS, "R10");         // old page gone

    rd(16'h0200, MISS_WS, "R5");          // next request waits behind the miss
    rd(16'h0201, 0, "R5");

    repeat (2) @(posedge clk); #1;
    pulse_flush();
    rd(16'h0202, MISS_WS, "R6");
    rd(16'h0203, 0, "R6");

    rd(16'h0201, MISS_WS, "R7", 1'b1);    // flush at acceptance forces miss
    rd(16'h0200, 0, "R7");

    fork
      rd(16'h0300, MISS_WS, "R8");
      begin @(posedge clk); #1; flush = 1'b1; @(posedge clk); #1; flush = 1'b0; end
    join
    rd(16'h0301, MISS_WS, "R8");          // page left invalid
    rd(16'h0302, 0, "R8");

    for (int p = 0; p < 4; p++) begin
      rd(ADDR_W'(16'h0400 + p*4 + 3), MISS_WS, "R3");
      for (int w = 0; w < 3; w++) rd(ADDR_W'(16'h0400 + p*4 + w), 0, "R2");
    end

    repeat (6) @(posedge clk);
    check(sb.size() == 0, "R4", "scoreboard drained", sb.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule